// File: doc/BRIEF.md
# Floating-Point Special-Value Trap

This block sits beside the operand buses of the floating-point units. It checks every single-precision operand as it goes past and looks for two kinds of special value: infinity and NaN. The block has two lanes, A and B, so it can check up to two operands per clock. Each operand comes with a valid bit, the program counter of its instruction and the number of the register it was read from. The block only observes the buses. It has no ready signal and never applies back-pressure, so every operand is examined in the cycle it is presented, and the pipeline is never slowed or halted.

When the first special value is seen, the block records a snapshot in its capture registers:

- the program counter;
- the source register number;
- the kind of value (infinity or NaN);
- the lane it arrived on;
- the value of a free-running cycle counter.

It then sets a sticky flag. While the flag is set, later special values are ignored. Software reads the snapshot through a small register port. Writing a clear command drops the flag and re-arms the trap; the snapshot itself stays readable until the next capture.

Register map (32-bit words, selected by `csr_addr`, read combinationally on `csr_rdata`):

| Address | Contents |
|---|---|
| 0 | Status. Bit 0 is the flag, bits 2:1 are the kind code, bit 3 is the lane. Writing a 1 to bit 0 clears the flag. |
| 1 | Captured program counter. |
| 2 | Captured source register number. |
| 3 | Cycle count, bits 31:0. |
| 4 | Cycle count, bits 63:32. |
| other | Reads as 0. |

Top module: `fp_special_trap`

## Requirements
- R1: After reset, `trap_flag` is 0 and every register address reads 0.
- R2: An operand is special when its 8-bit exponent field (bits 30:23) is all ones, whatever its sign. A zero mantissa gives kind code 2'b01 (infinity) and a nonzero mantissa gives 2'b10 (NaN). Zeros, denormals and the largest finite values never trigger.
- R3: On a valid special operand while the flag is clear, the clock edge that samples it sets `trap_flag`. The same edge latches the operand's program counter, its source register, the kind code and the cycle-counter value of that cycle.
- R4: An operand whose valid bit is low is never examined, whatever its data.
- R5: If both lanes carry special operands in the same cycle, lane A is captured and status bit 3 reads 0. A capture from lane B sets status bit 3 to 1.
- R6: While the flag is set, later special operands change neither the flag nor any captured field.
- R7: Writing address 0 with bit 0 set clears the flag on the next edge and keeps the captured fields readable. Writing bit 0 as 0, or writing any other address, has no effect.
- R8: A clear write in the same cycle as a special operand does the following. If the flag was set, the operand is ignored and the flag clears. If the flag was already clear, the operand is captured and the flag is set.
- R9: The cycle counter starts at 0 at reset, counts every clock and wraps silently at its width (48 bits by default, set by parameter `CNT_W`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a_valid | input | 1 | Lane A operand present |
| a_data | input | 32 | Lane A single-precision operand |
| a_pc | input | PC_W | Lane A instruction address |
| a_src | input | REG_W | Lane A source register number |
| b_valid | input | 1 | Lane B operand present |
| b_data | input | 32 | Lane B single-precision operand |
| b_pc | input | PC_W | Lane B instruction address |
| b_src | input | REG_W | Lane B source register number |
| csr_addr | input | 3 | Register select |
| csr_wr | input | 1 | Write strobe |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Read data for `csr_addr` |
| trap_flag | output | 1 | Sticky detection flag |

## Verification
A wrong classification or a wrong lane priority shows up at the next clock edge. It appears as a missing or spurious `trap_flag`, or as a wrong program counter, kind or lane in the registers read right after. A sticky bit that leaks lets a later operand overwrite the snapshot, and that shows on the next register read. A counter that drops or repeats a count gives a wrong captured cycle on every detection afterwards. A second instance with a narrow counter brings the wrap-around out to the ports within a hundred cycles.

// File: rtl/fpt_pkg.sv
package fpt_pkg;
  localparam int CSR_AW = 3;

  localparam logic [CSR_AW-1:0] ADDR_STATUS = 3'd0;
  localparam logic [CSR_AW-1:0] ADDR_PC     = 3'd1;
  localparam logic [CSR_AW-1:0] ADDR_SRC    = 3'd2;
  localparam logic [CSR_AW-1:0] ADDR_CYC_LO = 3'd3;
  localparam logic [CSR_AW-1:0] ADDR_CYC_HI = 3'd4;

  typedef enum logic [1:0] {
    KIND_NONE = 2'b00,
    KIND_INF  = 2'b01,
    KIND_NAN  = 2'b10
  } fp_kind_e;
endpackage

// File: rtl/fpt_lane_classify.sv
module fpt_lane_classify #(
  parameter int EXP_W  = 8,
  parameter int MANT_W = 23,
  localparam int DATA_W = 1 + EXP_W + MANT_W
) (
  input  logic              valid,
  input  logic [DATA_W-1:0] data,
  output logic              hit,
  output logic [1:0]        kind
);
  import fpt_pkg::*;

  logic [EXP_W-1:0]  exp_f;
  logic [MANT_W-1:0] mant_f;
  logic              exp_max;

  assign exp_f   = data[DATA_W-2 -: EXP_W];
  assign mant_f  = data[MANT_W-1:0];
  assign exp_max = &exp_f;

  always_comb begin
    kind = KIND_NONE;
    if (valid && exp_max) begin
      kind = (|mant_f) ? KIND_NAN : KIND_INF;
    end
  end

  assign hit = (kind != KIND_NONE);
endmodule

// File: rtl/fpt_cycle_ctr.sv
module fpt_cycle_ctr #(
  parameter int CNT_W = 48
) (
  input  logic             clk,
  input  logic             rst,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst) count <= '0;
    else     count <= count + CNT_W'(1);
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> count == CNT_W'($past(count) + CNT_W'(1))); // R9
endmodule

// File: rtl/fpt_capture.sv
module fpt_capture #(
  parameter int LANES = 2,
  parameter int PC_W  = 32,
  parameter int REG_W = 5,
  parameter int CNT_W = 48,
  localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [LANES-1:0]            hit,
  input  logic [LANES-1:0][1:0]       kind,
  input  logic [LANES-1:0][PC_W-1:0]  pc,
  input  logic [LANES-1:0][REG_W-1:0] src,
  input  logic [CNT_W-1:0]            cycle,
  input  logic                        clr,
  output logic                        sticky,
  output logic [PC_W-1:0]             cap_pc,
  output logic [REG_W-1:0]            cap_src,
  output logic [CNT_W-1:0]            cap_cyc,
  output logic [1:0]                  cap_kind,
  output logic [LANE_W-1:0]           cap_lane
);
  logic              sel_hit;
  logic [LANE_W-1:0] sel_idx;
  logic              take;

  // Lowest lane index wins: scan downward so the last assignment is lane 0.
  always_comb begin
    sel_hit = 1'b0;
    sel_idx = '0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (hit[i]) begin
        sel_hit = 1'b1;
        sel_idx = LANE_W'(i);
      end
    end
  end

  assign take = sel_hit && !sticky;

  always_ff @(posedge clk) begin
    if (rst) begin
      sticky   <= 1'b0;
      cap_pc   <= '0;
      cap_src  <= '0;
      cap_cyc  <= '0;
      cap_kind <= '0;
      cap_lane <= '0;
    end else if (take) begin
      sticky   <= 1'b1;
      cap_pc   <= pc[sel_idx];
      cap_src  <= src[sel_idx];
      cap_cyc  <= cycle;
      cap_kind <= kind[sel_idx];
      cap_lane <= sel_idx;
    end else if (clr) begin
      sticky   <= 1'b0;
    end
  end

  AST_FIRST_SETS: assert property (@(posedge clk) disable iff (rst)
    (!sticky && (|hit)) |=> sticky); // R3
  AST_LANE_A_WINS: assert property (@(posedge clk) disable iff (rst)
    (!sticky && hit[0]) |=> (cap_lane == '0)); // R5
  AST_HOLD_SNAPSHOT: assert property (@(posedge clk) disable iff (rst)
    sticky |=> ($stable(cap_pc) && $stable(cap_cyc) && $stable(cap_src) && $stable(cap_kind))); // R6
  AST_STAY_SET: assert property (@(posedge clk) disable iff (rst)
    (sticky && !clr) |=> sticky); // R6
  AST_CLR_REARM: assert property (@(posedge clk) disable iff (rst)
    (sticky && clr) |=> !sticky); // R7
endmodule

// File: rtl/fpt_csr.sv
module fpt_csr #(
  parameter int PC_W   = 32,
  parameter int REG_W  = 5,
  parameter int CNT_W  = 48,
  parameter int LANE_W = 1
) (
  input  logic [fpt_pkg::CSR_AW-1:0] addr,
  input  logic                       wr,
  input  logic [31:0]                wdata,
  input  logic                       sticky,
  input  logic [PC_W-1:0]            cap_pc,
  input  logic [REG_W-1:0]           cap_src,
  input  logic [CNT_W-1:0]           cap_cyc,
  input  logic [1:0]                 cap_kind,
  input  logic [LANE_W-1:0]          cap_lane,
  output logic [31:0]                rdata,
  output logic                       clr
);
  import fpt_pkg::*;

  logic [63:0] cyc64;
  logic [31:0] status;

  assign cyc64  = 64'(cap_cyc);
  assign status = {27'd0, cap_lane[0], cap_kind, sticky};
  assign clr    = wr && (addr == ADDR_STATUS) && wdata[0];

  always_comb begin
    unique case (addr)
      ADDR_STATUS: rdata = status;
      ADDR_PC:     rdata = 32'(cap_pc);
      ADDR_SRC:    rdata = 32'(cap_src);
      ADDR_CYC_LO: rdata = cyc64[31:0];
      ADDR_CYC_HI: rdata = cyc64[63:32];
      default:     rdata = 32'd0;
    endcase
  end
endmodule

// File: rtl/fp_special_trap.sv
module fp_special_trap #(
  parameter int PC_W   = 32,
  parameter int REG_W  = 5,
  parameter int CNT_W  = 48,
  parameter int EXP_W  = 8,
  parameter int MANT_W = 23,
  localparam int DATA_W = 1 + EXP_W + MANT_W,
  localparam int LANES  = 2,
  localparam int LANE_W = 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       a_valid,
  input  logic [DATA_W-1:0]          a_data,
  input  logic [PC_W-1:0]            a_pc,
  input  logic [REG_W-1:0]           a_src,
  input  logic                       b_valid,
  input  logic [DATA_W-1:0]          b_data,
  input  logic [PC_W-1:0]            b_pc,
  input  logic [REG_W-1:0]           b_src,
  input  logic [fpt_pkg::CSR_AW-1:0] csr_addr,
  input  logic                       csr_wr,
  input  logic [31:0]                csr_wdata,
  output logic [31:0]                csr_rdata,
  output logic                       trap_flag
);
  logic [LANES-1:0]              l_valid;
  logic [LANES-1:0][DATA_W-1:0]  l_data;
  logic [LANES-1:0][PC_W-1:0]    l_pc;
  logic [LANES-1:0][REG_W-1:0]   l_src;
  logic [LANES-1:0]              l_hit;
  logic [LANES-1:0][1:0]         l_kind;

  logic [CNT_W-1:0]  cycle;
  logic              clr;
  logic [PC_W-1:0]   cap_pc;
  logic [REG_W-1:0]  cap_src;
  logic [CNT_W-1:0]  cap_cyc;
  logic [1:0]        cap_kind;
  logic [LANE_W-1:0] cap_lane;

  assign l_valid = {b_valid, a_valid};
  assign l_data  = {b_data, a_data};
  assign l_pc    = {b_pc, a_pc};
  assign l_src   = {b_src, a_src};

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    fpt_lane_classify #(.EXP_W(EXP_W), .MANT_W(MANT_W)) u_cls (
      .valid (l_valid[g]),
      .data  (l_data[g]),
      .hit   (l_hit[g]),
      .kind  (l_kind[g])
    );
  end

  fpt_cycle_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk   (clk),
    .rst   (rst),
    .count (cycle)
  );

  fpt_capture #(.LANES(LANES), .PC_W(PC_W), .REG_W(REG_W), .CNT_W(CNT_W)) u_cap (
    .clk      (clk),
    .rst      (rst),
    .hit      (l_hit),
    .kind     (l_kind),
    .pc       (l_pc),
    .src      (l_src),
    .cycle    (cycle),
    .clr      (clr),
    .sticky   (trap_flag),
    .cap_pc   (cap_pc),
    .cap_src  (cap_src),
    .cap_cyc  (cap_cyc),
    .cap_kind (cap_kind),
    .cap_lane (cap_lane)
  );

  fpt_csr #(.PC_W(PC_W), .REG_W(REG_W), .CNT_W(CNT_W), .LANE_W(LANE_W)) u_csr (
    .addr     (csr_addr),
    .wr       (csr_wr),
    .wdata    (csr_wdata),
    .sticky   (trap_flag),
    .cap_pc   (cap_pc),
    .cap_src  (cap_src),
    .cap_cyc  (cap_cyc),
    .cap_kind (cap_kind),
    .cap_lane (cap_lane),
    .rdata    (csr_rdata),
    .clr      (clr)
  );

  AST_INVALID_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!a_valid && !b_valid) |=> ($past(trap_flag) || !trap_flag)); // R4
  AST_FLAG_HAS_KIND: assert property (@(posedge clk) disable iff (rst)
    trap_flag |-> (cap_kind != 2'b00)); // R2
  AST_RISE_NEEDS_HIT: assert property (@(posedge clk) disable iff (rst)
    $rose(trap_flag) |-> $past(|l_hit)); // R3
endmodule

// File: tb/tb_fp_special_trap.sv
module tb_fp_special_trap;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        a_valid = 0, b_valid = 0;
  logic [31:0] a_data = 0, b_data = 0, a_pc = 0, b_pc = 0;
  logic [4:0]  a_src = 0, b_src = 0;
  logic [2:0]  csr_addr = 0;
  logic        csr_wr = 0;
  logic [31:0] csr_wdata = 0;
  logic [31:0] csr_rdata, csr_rdata_w;
  logic        trap_flag, trap_flag_w;
  logic [63:0] tb_cyc;
  int          errors = 0, checks = 0;

  always #2 clk = ~clk;

  fp_special_trap dut (
    .clk(clk), .rst(rst),
    .a_valid(a_valid), .a_data(a_data), .a_pc(a_pc), .a_src(a_src),
    .b_valid(b_valid), .b_data(b_data), .b_pc(b_pc), .b_src(b_src),
    .csr_addr(csr_addr), .csr_wr(csr_wr), .csr_wdata(csr_wdata),
    .csr_rdata(csr_rdata), .trap_flag(trap_flag));

  fp_special_trap #(.CNT_W(6)) dut_w (
    .clk(clk), .rst(rst),
    .a_valid(a_valid), .a_data(a_data), .a_pc(a_pc), .a_src(a_src),
    .b_valid(b_valid), .b_data(b_data), .b_pc(b_pc), .b_src(b_src),
    .csr_addr(csr_addr), .csr_wr(csr_wr), .csr_wdata(csr_wdata),
    .csr_rdata(csr_rdata_w), .trap_flag(trap_flag_w));

  always_ff @(posedge clk) begin
    if (rst) tb_cyc <= 64'd0;
    else     tb_cyc <= tb_cyc + 64'd1;
  end

  function automatic logic [1:0] kind_of(input logic v, input logic [31:0] d);
    if (!v || d[30:23] != 8'hFF) return 2'b00;
    return (d[22:0] != 0) ? 2'b10 : 2'b01;
  endfunction

  function automatic logic [31:0] gen_op();
    int unsigned r = $urandom % 100;
    logic s = 1'($urandom);
    if (r < 4) return {s, 8'hFF, 23'd0};
    if (r < 8) return {s, 8'hFF, 23'(($urandom % 32'h7FFFFF) + 1)};
    return {s, 8'($urandom % 255), 23'($urandom)};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic va, input logic [31:0] da, input logic [31:0] pa, input logic [4:0] ra,
                       input logic vb, input logic [31:0] db, input logic [31:0] pb, input logic [4:0] rb);
    @(negedge clk);
    a_valid = va; a_data = da; a_pc = pa; a_src = ra;
    b_valid = vb; b_data = db; b_pc = pb; b_src = rb;
  endtask

  task automatic idle();
    @(negedge clk);
    a_valid = 0; b_valid = 0; csr_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d, output logic [31:0] dw);
    @(negedge clk);
    a_valid = 0; b_valid = 0; csr_wr = 0; csr_addr = a;
    #1; d = csr_rdata; dw = csr_rdata_w;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    a_valid = 0; b_valid = 0; csr_addr = a; csr_wdata = d; csr_wr = 1;
    @(negedge clk);
    csr_wr = 0;
  endtask

  task automatic expect_snap(input string req, input logic flag, input logic [31:0] pc, input logic [4:0] src,
                             input logic [1:0] kind, input logic lane, input logic [63:0] cyc);
    logic [31:0] d, dw;
    rd(3'd0, d, dw); check({req, " status"}, d, {27'd0, lane, kind, flag});
    check({req, " flag pin"}, trap_flag, flag);
    rd(3'd1, d, dw); check({req, " pc"}, d, pc);
    rd(3'd2, d, dw); check({req, " src"}, d, 32'(src));
    rd(3'd3, d, dw); check({req, " cyc lo"}, d, cyc[31:0]);
    check("R9 narrow counter wrap", dw, cyc % 64);
    rd(3'd4, d, dw); check({req, " cyc hi"}, d, cyc[63:32]);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin : main
    logic [31:0] d, dw;
    logic [63:0] ecyc;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst = 0;

    // R1: reset state
    check("R1 flag", trap_flag, 0);
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), d, dw);
      check("R1 reg", d, 0);
    end

    // Advance past 64 cycles so the narrow counter has wrapped
    repeat (70) @(negedge clk);

    // R4: invalid special operands ignored
    drive(0, 32'h7F800000, 32'h100, 5'd1, 0, 32'h7FC00000, 32'h104, 5'd2);
    idle();
    check("R4 invalid ignored", trap_flag, 0);

    // R2: zero, denormal, max finite, negative zero do not trigger
    drive(1, 32'h00000000, 32'h10, 5'd1, 1, 32'h00000001, 32'h14, 5'd2);
    drive(1, 32'h7F7FFFFF, 32'h18, 5'd3, 1, 32'h80000000, 32'h1C, 5'd4);
    idle();
    check("R2 non-special quiet", trap_flag, 0);

    // R3/R5/R2: lane B NaN captured with lane A finite
    drive(1, 32'h7F7FFFFF, 32'h200, 5'd3, 1, 32'hFFC00001, 32'h204, 5'd9);
    ecyc = tb_cyc;
    idle();
    expect_snap("R3 R5 lane B NaN", 1, 32'h204, 5'd9, 2'b10, 1, ecyc);

    // R6: later special on A does not overwrite
    drive(1, 32'h7F800000, 32'h300, 5'd7, 0, 0, 0, 0);
    idle();
    expect_snap("R6 sticky hold", 1, 32'h204, 5'd9, 2'b10, 1, ecyc);

    // R7: write bit0=0 and other-address writes do nothing
    wr(3'd0, 32'hFFFFFFFE);
    wr(3'd1, 32'h1);
    wr(3'd3, 32'hFFFFFFFF);
    expect_snap("R7 no-op writes", 1, 32'h204, 5'd9, 2'b10, 1, ecyc);

    // R7: clear keeps snapshot
    wr(3'd0, 32'h1);
    expect_snap("R7 clear keeps", 0, 32'h204, 5'd9, 2'b10, 1, ecyc);

    // R5/R2: both special, lane A (negative infinity) wins
    drive(1, 32'hFF800000, 32'h400, 5'd11, 1, 32'h7FFFFFFF, 32'h404, 5'd12);
    ecyc = tb_cyc;
    idle();
    expect_snap("R5 A priority", 1, 32'h400, 5'd11, 2'b01, 0, ecyc);

    // R8: clear with detection while flag set -> ignored, flag clears
    @(negedge clk);
    csr_addr = 0; csr_wdata = 1; csr_wr = 1;
    a_valid = 1; a_data = 32'h7FC00000; a_pc = 32'h500; a_src = 5'd13;
    idle();
    expect_snap("R8 clear wins over hit", 0, 32'h400, 5'd11, 2'b01, 0, ecyc);

    // R8: clear with detection while flag clear -> captured
    @(negedge clk);
    csr_addr = 0; csr_wdata = 1; csr_wr = 1;
    b_valid = 1; b_data = 32'h7F800000; b_pc = 32'h600; b_src = 5'd14;
    ecyc = tb_cyc;
    idle();
    expect_snap("R8 hit wins when clear", 1, 32'h600, 5'd14, 2'b01, 1, ecyc);

    // Random phase: R2 R3 R5 R6 R9
    for (int it = 0; it < 60; it++) begin
      logic found, lane, va, vb;
      logic [1:0]  kind, ka, kb;
      logic [31:0] pc, da, db, pa, pb;
      logic [4:0]  src, ra, rb;
      wr(3'd0, 32'h1);
      found = 0; lane = 0; kind = 0; pc = 0; src = 0;
      for (int c = 0; c < 10; c++) begin
        va = 1'($urandom); vb = 1'($urandom);
        da = gen_op(); db = gen_op();
        pa = $urandom; pb = $urandom; ra = 5'($urandom); rb = 5'($urandom);
        drive(va, da, pa, ra, vb, db, pb, rb);
        ka = kind_of(va, da); kb = kind_of(vb, db);
        if (!found && ka != 0) begin
          found = 1; lane = 0; kind = ka; pc = pa; src = ra; ecyc = tb_cyc;
        end else if (!found && kb != 0) begin
          found = 1; lane = 1; kind = kb; pc = pb; src = rb; ecyc = tb_cyc;
        end
      end
      idle();
      if (found) expect_snap("R3 random", 1, pc, src, kind, lane, ecyc);
      else check("R2 random no detect", trap_flag, 0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule